// File: doc/BRIEF.md
# First-Fit Queue Buffer Page Allocator

This block manages placement of queue buffers inside a shared buffer SRAM. The SRAM is split into 128 pages of 16 dwords. A 128-bit occupancy map records which pages are taken. The lowest few pages are held back for configuration use and are never handed out. For each of 64 queues the block keeps one 32-bit configuration word, and a queue counts as in use while its word is nonzero.

An allocation request names a queue, a buffer length in dwords and two watermarks, one for nearly empty and one for nearly full. The block first validates the request and checks that the queue is free. It then walks candidate start pages upward from page 0, one page per clock, and takes the first run of free pages that is long enough. Starts are not aligned to the run size. It marks the run used, stores the packed configuration word and reports the outcome. A release request decodes the queue's word, frees its pages and clears the word. Software can read any configuration word at any time through a separate combinational read port.

Requests enter over a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While the block is working, `req_ready` stays low and the requester must hold its request. Completion is a plain one-cycle `done` pulse carrying a status and a word. It has no back-pressure, so the consumer must take it in that cycle.

Top module: `qbuf_page_alloc`

## Requirements
- R1: After reset, every configuration word reads 0, pages 0 to 3 are marked used, `req_ready` is 1 and `done` is 0. A first 16-dword allocation therefore starts at page 4.
- R2: Lengths of 16, 32, 64 and 128 dwords map to size codes 0, 1, 2 and 3 and take 1, 2, 4 and 8 pages. Any other length completes with status 1 (invalid) and changes no state.
- R3: The watermark inputs are 4 bits wide. An allocation whose nearly-empty or nearly-full watermark has bit 3 set completes with status 1 (invalid) and changes no state.
- R4: An allocation whose target queue already has a nonzero word completes with status 2 (busy) and leaves that word unchanged. Invalid takes priority over busy.
- R5: A successful allocation takes the lowest start page at which every covered page is free. Candidates advance by a single page, not by the run size.
- R6: When no start page s with s + pages <= 128 has a free run, the request completes with status 3 (no memory) and changes no state.
- R7: The configuration word carries the start page in bits 21:14, the size code in bits 25:24, the nearly-empty watermark in bits 28:26 and the nearly-full watermark in bits 31:29. All other bits are 0. `cfg_rd_word` shows the word of queue `cfg_rd_idx`.
- R8: A release of a queue with a nonzero word frees exactly the pages that word describes, writes the word to 0 and completes with status 0 (ok). Later allocations may reuse the freed pages.
- R9: A release of a queue whose word is 0 completes with status 1 (invalid) and has no effect on any word or on the page map.
- R10: `req_ready` is high exactly when the block is idle. Each accepted request yields exactly one single-cycle `done` pulse. `done_word` is the newly written word for a successful allocation and 0 for every other outcome. Status codes: 0 ok, 1 invalid, 2 busy, 3 no memory.
- R11: Measured from the clock edge that accepts a request, `done` appears after 1 edge for release and for invalid or busy outcomes. A successful allocation at start page S takes S + 2 edges. A no-memory outcome for a run of P pages takes 130 - P edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 1 | 0 allocate, 1 release |
| req_qid | input | 6 | Target queue |
| req_len | input | 9 | Buffer length in dwords (allocate) |
| req_ne_wm | input | 4 | Nearly-empty watermark (allocate) |
| req_nf_wm | input | 4 | Nearly-full watermark (allocate) |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 invalid, 2 busy, 3 no memory |
| done_word | output | 32 | Word written by a successful allocation, else 0 |
| cfg_rd_idx | input | 6 | Queue whose configuration word is read |
| cfg_rd_word | output | 32 | Configuration word of `cfg_rd_idx` |

## Verification
The bound checker watches the handshake and the completion shape on every cycle. It checks that the reserved pages never leave the occupancy map, that `done` never lasts two cycles or appears while busy, and that an accepted request drops `req_ready`. It also checks that any word reported on `done` has its unused bits clear, a start page at or above the reserved pages and a run that ends inside the SRAM, and that every error outcome reports a zero word. First-fit placement into holes left by releases, the no-memory point after the buffer fills, the invisible effect of rejected and ignored requests, and the exact scan latency depend on history. Only the bench's scenarios can show these, by comparing each completion with a reference model of the page map and the queue words.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  localparam int CFG_W     = 32;
  localparam int START_LSB = 14;
  localparam int START_W   = 8;
  localparam int SIZE_LSB  = 24;
  localparam int SIZE_W    = 2;
  localparam int NE_LSB    = 26;
  localparam int NF_LSB    = 29;
  localparam int WM_W      = 3;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_BUSY    = 2'd2,
    ST_NOMEM   = 2'd3
  } qpa_status_e;

  typedef enum logic {
    OP_ALLOC   = 1'b0,
    OP_RELEASE = 1'b1
  } qpa_op_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_DECODE = 2'd1,
    S_SCAN   = 2'd2
  } qpa_state_e;
endpackage

// File: rtl/qpa_req_check.sv
module qpa_req_check #(
  parameter int LEN_W    = 9,
  parameter int WM_IN_W  = 4,
  parameter int BASE_LEN = 16,
  parameter int NSIZES   = 4
) (
  input  logic [LEN_W-1:0]   len,
  input  logic [WM_IN_W-1:0] ne_wm,
  input  logic [WM_IN_W-1:0] nf_wm,
  output logic               fmt_ok,
  output logic [1:0]         size_code
);
  import qpa_pkg::*;

  logic len_ok;
  logic wm_ok;

  // Length must be BASE_LEN times a power of two, up to NSIZES codes.
  always_comb begin
    len_ok    = 1'b0;
    size_code = '0;
    for (int k = 0; k < NSIZES; k++) begin
      if (len == LEN_W'(BASE_LEN << k)) begin
        len_ok    = 1'b1;
        size_code = 2'(k);
      end
    end
  end

  // Watermarks fit in WM_W bits.
  assign wm_ok  = ((ne_wm >> WM_W) == '0) && ((nf_wm >> WM_W) == '0);
  assign fmt_ok = len_ok && wm_ok;
endmodule

// File: rtl/qpa_occupancy.sv
module qpa_occupancy #(
  parameter int PAGES      = 128,
  parameter int RSVD_PAGES = 4,
  parameter int SW         = 8,
  parameter int CW         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    win_start,
  input  logic [CW-1:0]    win_pages,
  input  logic             set_en,
  input  logic             clr_en,
  output logic             win_free,
  output logic [PAGES-1:0] occ_map
);
  localparam logic [PAGES-1:0] RSV_INIT = (PAGES'(1) << RSVD_PAGES) - PAGES'(1);

  logic [PAGES-1:0] in_win;
  logic [SW:0]      lo;
  logic [SW:0]      hi;

  assign lo = {1'b0, win_start};
  assign hi = {1'b0, win_start} + (SW+1)'(win_pages);

  // One window comparator per page.
  for (genvar g = 0; g < PAGES; g++) begin : g_pg
    localparam logic [SW:0] PG = (SW+1)'(g);
    assign in_win[g] = (lo <= PG) && (PG < hi);
  end

  assign win_free = ~|(in_win & occ_map);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_map <= RSV_INIT;
    end else begin
      occ_map <= (occ_map | (set_en ? in_win : '0)) & ~(clr_en ? in_win : '0);
    end
  end
endmodule

// File: rtl/qpa_cfg_store.sv
module qpa_cfg_store #(
  parameter int QUEUES = 64,
  parameter int CFG_W  = 32,
  parameter int QID_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QID_W-1:0] wr_idx,
  input  logic [CFG_W-1:0] wr_word,
  input  logic [QID_W-1:0] rd_a_idx,
  output logic [CFG_W-1:0] rd_a_word,
  input  logic [QID_W-1:0] rd_b_idx,
  output logic [CFG_W-1:0] rd_b_word
);
  logic [CFG_W-1:0] words [QUEUES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < QUEUES; q++) words[q] <= '0;
    end else if (wr_en) begin
      words[wr_idx] <= wr_word;
    end
  end

  assign rd_a_word = words[rd_a_idx];
  assign rd_b_word = words[rd_b_idx];
endmodule

// File: rtl/qbuf_page_alloc.sv
module qbuf_page_alloc #(
  parameter int PAGES      = 128,
  parameter int QUEUES     = 64,
  parameter int RSVD_PAGES = 4,
  parameter int BASE_LEN   = 16,
  parameter int NSIZES     = 4,
  parameter int LEN_W      = 9,
  parameter int WM_IN_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_op,
  input  logic [$clog2(QUEUES)-1:0]   req_qid,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [WM_IN_W-1:0]          req_ne_wm,
  input  logic [WM_IN_W-1:0]          req_nf_wm,
  output logic                        done,
  output logic [1:0]                  done_status,
  output logic [31:0]                 done_word,
  input  logic [$clog2(QUEUES)-1:0]   cfg_rd_idx,
  output logic [31:0]                 cfg_rd_word
);
  import qpa_pkg::*;

  localparam int QID_W = $clog2(QUEUES);
  localparam int SW    = $clog2(PAGES) + 1;
  localparam int CW    = NSIZES;

  qpa_state_e       state;
  logic             r_op;
  logic [QID_W-1:0] r_qid;
  logic [LEN_W-1:0] r_len;
  logic [WM_IN_W-1:0] r_ne;
  logic [WM_IN_W-1:0] r_nf;
  logic [SW-1:0]    cand;

  logic             fmt_ok;
  logic [1:0]       chk_size;
  logic [CFG_W-1:0] cur_word;
  logic [CFG_W-1:0] new_word;
  logic [SW-1:0]    rel_start;
  logic [1:0]       rel_size;
  logic [SW-1:0]    win_start;
  logic [1:0]       win_size;
  logic [CW-1:0]    win_pages;
  logic             win_free;
  logic             set_en;
  logic             clr_en;
  logic             scan_last;
  logic [PAGES-1:0] occ_map;

  assign req_ready = (state == S_IDLE);

  qpa_req_check #(
    .LEN_W(LEN_W), .WM_IN_W(WM_IN_W), .BASE_LEN(BASE_LEN), .NSIZES(NSIZES)
  ) u_check (
    .len(r_len), .ne_wm(r_ne), .nf_wm(r_nf),
    .fmt_ok(fmt_ok), .size_code(chk_size)
  );

  // Fields of the word held by the addressed queue (release path).
  assign rel_start = SW'(cur_word[START_LSB +: START_W]);
  assign rel_size  = cur_word[SIZE_LSB +: SIZE_W];

  // Page window: scanning candidate, or the run being released.
  assign win_start = (state == S_SCAN) ? cand : rel_start;
  assign win_size  = (state == S_SCAN) ? chk_size : rel_size;
  assign win_pages = CW'(1) << win_size;

  assign set_en = (state == S_SCAN) && win_free;
  assign clr_en = (state == S_DECODE) && (r_op == OP_RELEASE) && (cur_word != '0);

  assign scan_last = ({1'b0, cand} + (SW+1)'(win_pages)) >= (SW+1)'(PAGES);

  qpa_occupancy #(
    .PAGES(PAGES), .RSVD_PAGES(RSVD_PAGES), .SW(SW), .CW(CW)
  ) u_occ (
    .clk(clk), .rst_n(rst_n),
    .win_start(win_start), .win_pages(win_pages),
    .set_en(set_en), .clr_en(clr_en),
    .win_free(win_free), .occ_map(occ_map)
  );

  always_comb begin
    new_word = '0;
    new_word[START_LSB +: START_W] = START_W'(cand);
    new_word[SIZE_LSB +: SIZE_W]   = chk_size;
    new_word[NE_LSB +: WM_W]       = r_ne[WM_W-1:0];
    new_word[NF_LSB +: WM_W]       = r_nf[WM_W-1:0];
  end

  qpa_cfg_store #(
    .QUEUES(QUEUES), .CFG_W(CFG_W), .QID_W(QID_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(set_en || clr_en), .wr_idx(r_qid),
    .wr_word(set_en ? new_word : '0),
    .rd_a_idx(r_qid), .rd_a_word(cur_word),
    .rd_b_idx(cfg_rd_idx), .rd_b_word(cfg_rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      r_op        <= 1'b0;
      r_qid       <= '0;
      r_len       <= '0;
      r_ne        <= '0;
      r_nf        <= '0;
      cand        <= '0;
      done        <= 1'b0;
      done_status <= ST_OK;
      done_word   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            r_op  <= req_op;
            r_qid <= req_qid;
            r_len <= req_len;
            r_ne  <= req_ne_wm;
            r_nf  <= req_nf_wm;
            state <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (r_op == OP_ALLOC) begin
            if (!fmt_ok) begin
              done <= 1'b1; done_status <= ST_INVALID; done_word <= '0;
              state <= S_IDLE;
            end else if (cur_word != '0) begin
              done <= 1'b1; done_status <= ST_BUSY; done_word <= '0;
              state <= S_IDLE;
            end else begin
              cand  <= '0;
              state <= S_SCAN;
            end
          end else begin
            done      <= 1'b1;
            done_word <= '0;
            done_status <= (cur_word != '0) ? ST_OK : ST_INVALID;
            state     <= S_IDLE;
          end
        end
        S_SCAN: begin
          if (win_free) begin
            done <= 1'b1; done_status <= ST_OK; done_word <= new_word;
            state <= S_IDLE;
          end else if (scan_last) begin
            done <= 1'b1; done_status <= ST_NOMEM; done_word <= '0;
            state <= S_IDLE;
          end else begin
            cand <= cand + SW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpa_checker.sv
module qpa_checker #(
  parameter int PAGES      = 128,
  parameter int RSVD_PAGES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  done,
  input logic [1:0]            done_status,
  input logic [31:0]           done_word,
  input logic [RSVD_PAGES-1:0] occ_low
);
  // R1: reserved pages stay marked used
  a_r1_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    &occ_low);

  // R10: completion lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: accepting a request makes the block busy, no instant completion
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !done));

  // R10: completion only seen when idle again
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R7: reported word has clear unused bits and ok status
  a_r7_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_word != 32'd0) |->
      (done_word[13:0] == 14'd0 && done_word[23:22] == 2'd0 && done_status == 2'd0));

  // R5: placed run sits above reserved pages and ends inside the buffer
  a_r5_run_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_word != 32'd0) |->
      ((({2'b0, done_word[21:14]} + (10'd1 << done_word[25:24])) <= 10'(PAGES)) &&
       (done_word[21:14] >= 8'(RSVD_PAGES))));

  // R6: error outcomes report a zero word
  a_r6_error_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status != 2'd0) |-> done_word == 32'd0);
endmodule

bind qbuf_page_alloc qpa_checker #(.PAGES(PAGES), .RSVD_PAGES(RSVD_PAGES)) u_qpa_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_status(done_status), .done_word(done_word),
  .occ_low(occ_map[RSVD_PAGES-1:0])
);

// File: tb/qbuf_page_alloc_tb_top.sv
`timescale 1ns/1ps
module qbuf_page_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [5:0]  req_qid = '0;
  logic [8:0]  req_len = '0;
  logic [3:0]  req_ne_wm = '0;
  logic [3:0]  req_nf_wm = '0;
  logic        done;
  logic [1:0]  done_status;
  logic [31:0] done_word;
  logic [5:0]  cfg_rd_idx = '0;
  logic [31:0] cfg_rd_word;

  always #2.5 clk = ~clk;

  qbuf_page_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_qid(req_qid), .req_len(req_len),
    .req_ne_wm(req_ne_wm), .req_nf_wm(req_nf_wm),
    .done(done), .done_status(done_status), .done_word(done_word),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_word(cfg_rd_word)
  );

  typedef struct {
    logic [1:0]  st;
    logic [31:0] word;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  bit          mbm[128];
  logic [31:0] mcfg[64];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int acc_cyc = 0;
  bit ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each completion with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(done_status == e.st, e.tag, "status", done_status, e.st);
        check(done_word == e.word, e.tag, "done_word", done_word, e.word);
        check((cyc - acc_cyc) == e.lat, "R11", "latency", cyc - acc_cyc, e.lat);
      end
    end
  end

  // Driver: predicts the outcome from the model, then drives the request.
  task automatic submit(bit op, int qid, int len, int ne, int nf, string tag);
    exp_t e;
    int code, p, found;
    e.tag = tag; e.word = '0; e.lat = 1;
    if (op == 1'b0) begin
      code = -1;
      case (len)
        16: code = 0; 32: code = 1; 64: code = 2; 128: code = 3;
        default: code = -1;
      endcase
      if (code < 0 || ne > 7 || nf > 7) e.st = 2'd1;
      else if (mcfg[qid] != 0) e.st = 2'd2;
      else begin
        p = 1 << code;
        found = -1;
        for (int s = 0; s + p <= 128; s++) begin
          bit fr = 1'b1;
          for (int k = 0; k < p; k++) if (mbm[s+k]) fr = 1'b0;
          if (fr) begin found = s; break; end
        end
        if (found < 0) begin
          e.st = 2'd3; e.lat = 130 - p;
        end else begin
          e.st = 2'd0; e.lat = found + 2;
          e.word = (32'(nf) << 29) | (32'(ne) << 26) | (32'(code) << 24) | (32'(found) << 14);
          for (int k = 0; k < p; k++) mbm[found+k] = 1'b1;
          mcfg[qid] = e.word;
        end
      end
    end else begin
      if (mcfg[qid] == 0) e.st = 2'd1;
      else begin
        int st0 = int'(mcfg[qid][21:14]);
        p = 1 << mcfg[qid][25:24];
        for (int k = 0; k < p; k++) mbm[st0+k] = 1'b0;
        mcfg[qid] = '0;
        e.st = 2'd0;
      end
    end
    sb.push_back(e);
    while (!req_ready) @(negedge clk);
    req_op = op; req_qid = 6'(qid); req_len = 9'(len);
    req_ne_wm = 4'(ne); req_nf_wm = 4'(nf); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic rd_check(int qid, string tag);
    @(negedge clk);
    cfg_rd_idx = 6'(qid);
    #1;
    check(cfg_rd_word == mcfg[qid], tag, "config word readback", cfg_rd_word, mcfg[qid]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mbm[i] = (i < 4);
    for (int q = 0; q < 64; q++) mcfg[q] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    rd_check(0, "R1");
    rd_check(63, "R1");

    // R1 R7: first alloc lands after reserved pages, fields packed
    submit(0, 0, 16, 1, 2, "R1");
    rd_check(0, "R7");
    // R2 R5: every size, unaligned first-fit placement
    submit(0, 1, 32, 5, 7, "R2");
    submit(0, 2, 64, 0, 3, "R5");
    submit(0, 3, 128, 7, 0, "R2");
    rd_check(3, "R7");
    // R2 invalid lengths, R3 wide watermarks
    submit(0, 9, 48, 0, 0, "R2");
    submit(0, 9, 0, 0, 0, "R2");
    submit(0, 9, 256, 0, 0, "R2");
    submit(0, 9, 16, 8, 0, "R3");
    submit(0, 9, 16, 0, 9, "R3");
    rd_check(9, "R3");
    // R4 busy queue, word untouched; invalid beats busy
    submit(0, 0, 32, 0, 0, "R4");
    submit(0, 0, 20, 0, 0, "R4");
    rd_check(0, "R4");
    // R9 release of unused queue
    submit(1, 10, 0, 0, 0, "R9");
    rd_check(10, "R9");
    // R8 release then reuse hole, R5 first-fit into hole
    submit(1, 1, 0, 0, 0, "R8");
    rd_check(1, "R8");
    submit(0, 4, 16, 2, 2, "R5");
    submit(0, 5, 32, 3, 4, "R5");
    submit(0, 6, 16, 6, 1, "R8");
    // R6 fill buffer until no memory
    for (int q = 20; q < 36; q++) submit(0, q, 128, 1, 1, "R6");
    submit(0, 40, 64, 0, 0, "R6");
    submit(0, 41, 32, 0, 0, "R6");
    submit(0, 42, 16, 0, 0, "R6");
    submit(0, 43, 16, 0, 0, "R6");
    // R8 release everything, words clear, space reusable
    for (int q = 0; q < 64; q++) if (mcfg[q] != 0) submit(1, q, 0, 0, 0, "R8");
    rd_check(20, "R8");
    rd_check(5, "R8");
    submit(0, 7, 128, 4, 5, "R8");
    submit(0, 8, 128, 4, 5, "R5");
    rd_check(8, "R7");

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule